// File: doc/BRIEF.md
# Horizontal Drive Pulse Generator

This block produces the line-rate drive pulse for a horizontal output stage. A counter running on the fast timing clock divides it down to the line period. In free-running mode the pulse is low for exactly the first half of each period. In locked mode the counter follows the rising edges of a line reference supplied by an upstream phase loop, and the pulse is low for a programmed number of clocks. The output is active-low, which suits an open-drain pad.

Out of reset the generator always runs free. It moves to locked operation only when a software enable bit and a supply-supervision flag are both true. It returns to free running as soon as either one drops.

Mode changes, width changes and reference captures take effect only at the start of a period. A reference edge that arrives well before the end of the count does not cut the period short. Instead, it advances the counter by a fixed slip step. This keeps every period inside a narrow band around nominal, even while the counter pulls into phase. A fine-phase input then delays the whole output by a whole number of clocks.

Top module: `hdrive_gen`

## Requirements
- R1: While reset is asserted the output `drive_n` is high. After reset is released the block is in free-running mode.
- R2: In free-running mode every period lasts PERIOD clocks: `drive_n` is low for PERIOD/2 clocks and then high for PERIOD/2 clocks. Neither `width_cfg` nor `line_ref` changes this.
- R3: Locked mode is entered only while `lock_en` and `supply_ok` are both 1. With `lock_en`=1 and `supply_ok`=0 the output stays in the R2 pattern.
- R4: In locked mode with a reference period T, where PERIOD-SLIP < T <= PERIOD, the output period becomes T. `drive_n` is low for the latched width and then high for the rest of the period.
- R5: If `supply_ok` or `lock_en` falls while locked, the block returns to free running at the next period start and then shows the R2 pattern.
- R6: A `width_cfg` value above PERIOD-GAP is clamped, so the low time is PERIOD-GAP clocks.
- R7: A `width_cfg` of 0 in locked mode produces no low level on `drive_n`.
- R8: The falling edge of `drive_n` comes 1+`phase_dly` clocks after the clock edge that first samples `line_ref` high in a locked, aligned period.
- R9: Every period lasts at least PERIOD-SLIP+1 and at most PERIOD clocks, including periods that contain a mode switch or a pull-in slip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_en | input | 1 | Software enable for locked operation |
| supply_ok | input | 1 | Supply supervision flag; 1 means the supply is good |
| line_ref | input | 1 | Line reference from the phase loop; only its rising edge matters |
| width_cfg | input | WIDTH_W | Locked-mode low time in clocks, latched at each period start |
| phase_dly | input | PHASE_W | Output delay in whole clocks |
| drive_n | output | 1 | Active-low drive pulse |

## Verification
A corrupted period counter shows up as a fall-to-fall interval outside the R9 band, and at the latest it appears at the next falling edge of `drive_n`. A wrong mode flag appears within one period as a low time of PERIOD/2 where the programmed width was expected, or the reverse. A slip applied in the wrong direction would stretch a period past PERIOD and would never bring the falling edge to the R8 offset. A broken delay tap shifts that offset on the very next pulse.

// File: rtl/hdrive_gen.sv
module hdrive_gen #(
  parameter int PERIOD  = 1728,
  parameter int SLIP    = 27,
  parameter int GAP     = 16,
  parameter int WIDTH_W = 10,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock_en,
  input  logic               supply_ok,
  input  logic               line_ref,
  input  logic [WIDTH_W-1:0] width_cfg,
  input  logic [PHASE_W-1:0] phase_dly,
  output logic               drive_n
);
  localparam int CNT_W  = $clog2(PERIOD);
  localparam int CMP_W  = ((CNT_W > WIDTH_W) ? CNT_W : WIDTH_W) + 1;
  localparam int HALF   = PERIOD / 2;
  localparam int LIMIT  = PERIOD - GAP;
  localparam int WIN_LO = PERIOD - SLIP;
  localparam int DEPTH  = 2 ** PHASE_W;

  logic [CNT_W-1:0] cnt;
  logic [CMP_W-1:0] width_q;
  logic [DEPTH-1:0] hist;
  logic             mode_q;
  logic             ref_q;

  logic             want;
  logic             ref_act;
  logic             reload;
  logic             act;
  logic [CMP_W-1:0] width_lim;

  assign want      = lock_en & supply_ok;
  assign ref_act   = line_ref & ~ref_q & (mode_q | want);
  assign reload    = (cnt == CNT_W'(PERIOD - 1)) | (ref_act & (cnt >= CNT_W'(WIN_LO)));
  assign width_lim = (CMP_W'(width_cfg) > CMP_W'(LIMIT)) ? CMP_W'(LIMIT) : CMP_W'(width_cfg);
  assign act       = mode_q ? (CMP_W'(cnt) < width_q) : (cnt < CNT_W'(HALF));
  assign drive_n   = ~hist[phase_dly];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      width_q <= '0;
      hist    <= '0;
      mode_q  <= 1'b0;
      ref_q   <= 1'b0;
    end else begin
      ref_q <= line_ref;
      hist  <= {hist[DEPTH-2:0], act};
      if (reload) begin
        cnt     <= '0;
        mode_q  <= want;
        width_q <= width_lim;
      end else if (ref_act) begin
        cnt <= cnt + CNT_W'(SLIP);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

module hdrive_gen_chk #(
  parameter int PERIOD = 1728,
  parameter int SLIP   = 27,
  parameter int CNT_W  = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_en,
  input logic             supply_ok,
  input logic             drive_n,
  input logic             mode_q,
  input logic [CNT_W-1:0] cnt
);
  logic [CNT_W:0] since;
  logic           seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (cnt == '0) begin
      since <= (CNT_W+1)'(1);
      seen  <= 1'b1;
    end else begin
      since <= since + 1'b1;
    end
  end

  a_r1_released_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> drive_n);

  a_r2_free_counts_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !(lock_en && supply_ok) && cnt != CNT_W'(PERIOD - 1))
      |=> cnt == CNT_W'($past(cnt) + 1'b1));

  a_r3_lock_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> $past(lock_en && supply_ok));

  a_r5_switch_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> cnt == '0);

  a_r9_period_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && cnt == '0) |-> (since >= (CNT_W+1)'(PERIOD - SLIP + 1) && since <= (CNT_W+1)'(PERIOD)));
endmodule

bind hdrive_gen hdrive_gen_chk #(
  .PERIOD(PERIOD), .SLIP(SLIP), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .supply_ok(supply_ok),
  .drive_n(drive_n), .mode_q(mode_q), .cnt(cnt)
);

// File: tb/hdrive_gen_tb_top.sv
`timescale 1ns/1ps
module hdrive_gen_tb_top;
  localparam int PERIOD = 64, SLIP = 8, GAP = 16, WIDTH_W = 6, PHASE_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_en = 1'b0;
  logic supply_ok = 1'b1;
  logic line_ref = 1'b0;
  logic [WIDTH_W-1:0] width_cfg = 6'd20;
  logic [PHASE_W-1:0] phase_dly = '0;
  logic drive_n;

  int checks = 0, fails = 0, cyc = 0, ref_cyc = 0, ref_per = 0, refcnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hdrive_gen #(.PERIOD(PERIOD), .SLIP(SLIP), .GAP(GAP), .WIDTH_W(WIDTH_W), .PHASE_W(PHASE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .supply_ok(supply_ok),
    .line_ref(line_ref), .width_cfg(width_cfg), .phase_dly(phase_dly), .drive_n(drive_n));

  initial begin
    forever begin
      @(negedge clk);
      if (ref_per == 0) begin
        line_ref = 1'b0;
        refcnt = 0;
      end else begin
        refcnt++;
        if (refcnt >= ref_per) begin
          refcnt = 0;
          line_ref = 1'b1;
          ref_cyc = cyc + 1;
        end else line_ref = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sample();
    @(posedge clk); #1;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) sample();
  endtask

  task automatic measure(output int lo, output int hi, output int ofs);
    while (drive_n !== 1'b1) sample();
    while (drive_n !== 1'b0) sample();
    ofs = cyc - ref_cyc;
    lo = 0;
    while (drive_n === 1'b0) begin lo++; sample(); end
    hi = 0;
    while (drive_n === 1'b1) begin hi++; sample(); end
  endtask

  task automatic next_fall(output int at);
    logic p;
    p = drive_n;
    forever begin
      sample();
      if (p === 1'b1 && drive_n === 1'b0) break;
      p = drive_n;
    end
    at = cyc;
  endtask

  task automatic t_reset();
    int lo, hi, ofs;
    wait_cycles(4);
    chk("R1 high in reset", int'(drive_n), 1);
    @(negedge clk); rst_n = 1'b1;
    measure(lo, hi, ofs);
    chk("R1 free low after reset", lo, PERIOD/2);
    chk("R1 free high after reset", hi, PERIOD/2);
  endtask

  task automatic t_free_ignores();
    int lo, hi, ofs;
    ref_per = 50; width_cfg = 6'd5;
    wait_cycles(3*PERIOD);
    measure(lo, hi, ofs);
    chk("R2 low with ref and width", lo, PERIOD/2);
    chk("R2 high with ref and width", hi, PERIOD/2);
  endtask

  task automatic t_no_supply();
    int lo, hi, ofs;
    ref_per = 60; width_cfg = 6'd20; lock_en = 1'b1; supply_ok = 1'b0;
    wait_cycles(4*PERIOD);
    measure(lo, hi, ofs);
    chk("R3 supply low keeps free low", lo, PERIOD/2);
    chk("R3 supply low keeps free period", lo + hi, PERIOD);
  endtask

  task automatic t_acquire();
    int lo, hi, ofs, prev, now, bad;
    ref_per = 64;
    next_fall(prev);
    supply_ok = 1'b1;
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      next_fall(now);
      if (now - prev < PERIOD - SLIP + 1 || now - prev > PERIOD) begin
        bad++;
        $display("FAIL R9 period %0d: got %0d expected %0d..%0d", i, now - prev, PERIOD - SLIP + 1, PERIOD);
      end
      prev = now;
    end
    checks++;
    if (bad != 0) fails++;
    wait_cycles(2*PERIOD);
    measure(lo, hi, ofs);
    chk("R4 locked low", lo, 20);
    chk("R4 locked high", hi, PERIOD - 20);
    chk("R8 offset phase 0", ofs, 1);
  endtask

  task automatic t_ref60();
    int lo, hi, ofs;
    ref_per = 60;
    wait_cycles(10*PERIOD);
    measure(lo, hi, ofs);
    chk("R4 period follows ref", lo + hi, 60);
    chk("R4 low at ref 60", lo, 20);
  endtask

  task automatic t_phase();
    int lo, hi, ofs;
    phase_dly = 4'd5;
    wait_cycles(3*PERIOD);
    measure(lo, hi, ofs);
    chk("R8 offset phase 5", ofs, 6);
    chk("R8 low kept with delay", lo, 20);
    phase_dly = 4'd15;
    wait_cycles(3*PERIOD);
    measure(lo, hi, ofs);
    chk("R8 offset phase 15", ofs, 16);
    phase_dly = '0;
    wait_cycles(2*PERIOD);
  endtask

  task automatic t_clamp();
    int lo, hi, ofs;
    width_cfg = 6'd60;
    wait_cycles(3*PERIOD);
    measure(lo, hi, ofs);
    chk("R6 clamped low", lo, PERIOD - GAP);
    chk("R6 clamped high", hi, 60 - (PERIOD - GAP));
  endtask

  task automatic t_zero();
    int lows;
    width_cfg = '0;
    wait_cycles(3*PERIOD);
    lows = 0;
    for (int i = 0; i < 3*PERIOD; i++) begin
      sample();
      if (drive_n !== 1'b1) lows++;
    end
    chk("R7 zero width no pulse", lows, 0);
  endtask

  task automatic t_fallback();
    int lo, hi, ofs;
    width_cfg = 6'd20;
    wait_cycles(3*PERIOD);
    supply_ok = 1'b0;
    wait_cycles(3*PERIOD);
    measure(lo, hi, ofs);
    chk("R5 supply loss low", lo, PERIOD/2);
    chk("R5 supply loss period", lo + hi, PERIOD);
    supply_ok = 1'b1;
    wait_cycles(10*PERIOD);
    measure(lo, hi, ofs);
    chk("R3 relock low", lo, 20);
    lock_en = 1'b0;
    wait_cycles(3*PERIOD);
    measure(lo, hi, ofs);
    chk("R5 enable cleared low", lo, PERIOD/2);
  endtask

  initial begin
    t_reset();
    t_free_ignores();
    t_no_supply();
    t_acquire();
    t_ref60();
    t_phase();
    t_clamp();
    t_zero();
    t_fallback();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule